// File: doc/BRIEF.md
# Lock State Seven-Segment Indicator

This block drives a single seven-segment digit that tells an observer which state a lock controller is in. Ordinary states are shown as their decimal index. The open (unlocked) state is shown as the letter U. The alarm state is shown as the letter A, and that letter flashes so that the alarm stands out.

The flashing comes from a free-running prescaler inside the block. It counts clock cycles while the alarm flag is high, and it flips a blank/visible phase each time it reaches a parameterised half-period. While the alarm flag is low, the prescaler is held at zero in the visible phase. Each new alarm therefore shows the glyph at once.

A small control module owns the prescaler and emits a struct of display strobes. A datapath module turns the strobes and the state index into segment lines.

Top module: `lock_state_display`

## Requirements
- R1: With both flags low, a state index of 0 to 9 drives `segOut` (bit 0 = segment a ... bit 6 = segment g, 1 = lit) to the decimal glyph. The codes are 0:0x3F, 1:0x06, 2:0x5B, 3:0x4F, 4:0x66, 5:0x6D, 6:0x7D, 7:0x07, 8:0x7F, 9:0x6F.
- R2: With both flags low, a state index above 9 blanks the digit (`segOut` = 0x00).
- R3: With `unlockFlag` high and `alarmFlag` low, `segOut` is the U glyph 0x3E, whatever the state index.
- R4: With `alarmFlag` high in a visible phase, `segOut` is the A glyph 0x77, whatever the state index and `unlockFlag`.
- R5: While `alarmFlag` stays high, counting the clock edges since it was first sampled high as n (n = 0 before the first edge), the glyph is visible when floor(n / BLINK_HALF) is even and `segOut` is 0x00 when it is odd.
- R6: One clock edge sampled with `alarmFlag` low restarts the prescaler. When the alarm returns, the A glyph is visible at once and blinking follows R5 counted from the new start.
- R7: A clock edge with `rst` high puts the prescaler in its visible start state. With `alarmFlag` high during reset, the A glyph is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stateIdx | input | STATE_W | Index of the lock controller's active state |
| unlockFlag | input | 1 | Lock is in its open state |
| alarmFlag | input | 1 | Lock is in its alarm state |
| segOut | output | 7 | Segment lines a..g, active high, bit 0 = a |

## Verification
The hardest condition to reach is the prescaler's restart in the middle of a blank half-period: the alarm flag must be dropped for exactly one edge while the digit is dark. The bench first runs a long alarm with a short BLINK_HALF and tracks the edge count so that it knows the blank phase arithmetically. At that point it pulses the alarm low for one cycle, and it then checks that the glyph reappears immediately and that the blink cadence is counted from the new start. Reset during a blank phase is reached in the same way.

// File: rtl/lock_disp_pkg.sv
package lock_disp_pkg;

  // Strobes from the control side to the segment datapath
  typedef struct packed {
    logic showAlarm;   // alarm glyph selected
    logic showUnlock;  // unlock glyph selected (only when no alarm)
    logic blankNow;    // blink phase says dark
  } dispCtrl_t;

  localparam int SEG_W = 7;

  localparam logic [SEG_W-1:0] GLYPH_U     = 7'h3E;
  localparam logic [SEG_W-1:0] GLYPH_A     = 7'h77;
  localparam logic [SEG_W-1:0] GLYPH_BLANK = 7'h00;

  // Decimal glyphs, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [SEG_W-1:0] digitGlyph(input logic [3:0] d);
    logic [SEG_W-1:0] g;
    case (d)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7D;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h6F;
      default: g = GLYPH_BLANK;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lock_disp_ctrl.sv
module lock_disp_ctrl
  import lock_disp_pkg::*;
#(
  parameter int BLINK_HALF = 62_500_000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      alarmFlag,
  input  logic      unlockFlag,
  output dispCtrl_t ctrl
);

  localparam int CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] prescaleCnt;
  logic             blinkPhase;
  logic             atTerm;

  assign atTerm = (prescaleCnt == TERM);

  always_ff @(posedge clk) begin
    if (rst || !alarmFlag) begin
      prescaleCnt <= '0;
      blinkPhase  <= 1'b0;
    end else if (atTerm) begin
      prescaleCnt <= '0;
      blinkPhase  <= ~blinkPhase;
    end else begin
      prescaleCnt <= prescaleCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.showAlarm  = alarmFlag;
    ctrl.showUnlock = unlockFlag && !alarmFlag;
    ctrl.blankNow   = alarmFlag && blinkPhase;
  end

  // R6: a low alarm sample returns the blink phase to visible
  assert_restart_visible_R6: assert property (@(posedge clk) disable iff (rst)
    !alarmFlag |=> !blinkPhase);

  // R7: reset leaves the prescaler in its visible start state
  assert_reset_visible_R7: assert property (@(posedge clk)
    rst |=> (!blinkPhase && prescaleCnt == '0));

  // R5: the counter never passes the terminal count
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    prescaleCnt <= TERM);

  // R5: the phase flips exactly when a held alarm meets the terminal count
  assert_phase_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (alarmFlag && atTerm) |=> (blinkPhase != $past(blinkPhase)));

  // R3/R4: the two glyph selects are never active together
  assert_glyph_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.showAlarm, ctrl.showUnlock}));

endmodule

// File: rtl/lock_disp_datapath.sv
module lock_disp_datapath
  import lock_disp_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] stateIdx,
  input  dispCtrl_t          ctrl,
  output logic [SEG_W-1:0]   segOut
);

  logic             inDecimal;
  logic [3:0]       digit;
  logic [SEG_W-1:0] numGlyph;

  // Wide indices are checked for range before the 4-bit narrowing
  generate
    if (STATE_W > 4) begin : g_wide
      assign inDecimal = (stateIdx <= STATE_W'(9));
      assign digit     = stateIdx[3:0];
    end else begin : g_narrow
      assign inDecimal = (4'(stateIdx) <= 4'd9);
      assign digit     = 4'(stateIdx);
    end
  endgenerate

  assign numGlyph = inDecimal ? digitGlyph(digit) : GLYPH_BLANK;

  always_comb begin
    if (ctrl.showAlarm)       segOut = ctrl.blankNow ? GLYPH_BLANK : GLYPH_A;
    else if (ctrl.showUnlock) segOut = GLYPH_U;
    else                      segOut = numGlyph;
  end

  // R4: a visible alarm shows the A glyph
  assert_alarm_glyph_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.showAlarm && !ctrl.blankNow) |-> segOut == 7'h77);

  // R3: unlock without alarm shows the U glyph
  assert_unlock_glyph_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.showUnlock && !ctrl.showAlarm) |-> segOut == 7'h3E);

  // R2: out-of-range index with no flag blanks the digit
  assert_range_blank_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.showAlarm && !ctrl.showUnlock && stateIdx > STATE_W'(9)) |-> segOut == '0);

endmodule

// File: rtl/lock_state_display.sv
module lock_state_display
  import lock_disp_pkg::*;
#(
  parameter int STATE_W    = 4,
  parameter int BLINK_HALF = 62_500_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] stateIdx,
  input  logic               unlockFlag,
  input  logic               alarmFlag,
  output logic [6:0]         segOut
);

  dispCtrl_t ctrl;

  lock_disp_ctrl #(.BLINK_HALF(BLINK_HALF)) u_ctrl (
    .clk(clk), .rst(rst), .alarmFlag(alarmFlag), .unlockFlag(unlockFlag), .ctrl(ctrl)
  );

  lock_disp_datapath #(.STATE_W(STATE_W)) u_dp (
    .clk(clk), .rst(rst), .stateIdx(stateIdx), .ctrl(ctrl), .segOut(segOut)
  );

endmodule

// File: tb/sim_lock_state_display.sv
`timescale 1ns/1ps
module sim_lock_state_display;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] stateIdx;
  logic       unlockFlag;
  logic       alarmFlag;
  logic [6:0] segOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  lock_state_display #(.STATE_W(4), .BLINK_HALF(HALF)) u0 (
    .clk(clk), .rst(rst), .stateIdx(stateIdx),
    .unlockFlag(unlockFlag), .alarmFlag(alarmFlag), .segOut(segOut)
  );

  function automatic logic [6:0] expDigit(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    nChecks++;
    if (segOut !== exp) begin
      nFails++;
      $display("FAIL %s: segOut=%h expected=%h (idx=%0d u=%b a=%b)",
               req, segOut, exp, stateIdx, unlockFlag, alarmFlag);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rst = 1; stateIdx = 0; unlockFlag = 0; alarmFlag = 0;
    step(); step();
    check("R7 reset idx0", 7'h3F);
    rst = 0; step();

    // R1/R2: all indices, no flags
    for (int i = 0; i < 16; i++) begin
      stateIdx = 4'(i); #1;
      check(i <= 9 ? "R1 digit" : "R2 blank", expDigit(i));
      step();
    end

    // R3: unlock over every index
    unlockFlag = 1;
    for (int i = 0; i < 16; i++) begin
      stateIdx = 4'(i); #1;
      check("R3 unlock", 7'h3E);
    end
    unlockFlag = 0; step();

    // R4: alarm at first sight, every index and unlock value
    for (int i = 0; i < 32; i++) begin
      alarmFlag = 1; stateIdx = 4'(i % 16); unlockFlag = i[4]; #1;
      check("R4 alarm glyph", 7'h77);
      alarmFlag = 0; step();
    end
    unlockFlag = 1; stateIdx = 4'd5;

    // R5: blink cadence from alarm start
    alarmFlag = 1; #1;
    check("R5 n=0", 7'h77);
    for (int n = 1; n <= 20; n++) begin
      step();
      check("R5 blink", ((n / HALF) % 2 == 0) ? 7'h77 : 7'h00);
    end
    // n = 20: floor(20/3)=6 visible; advance to n = 22 (7, blank)
    step(); step();
    check("R5 blank before restart", 7'h00);

    // R6: one low edge restarts the prescaler
    alarmFlag = 0; #1;
    check("R6 unlock during low", 7'h3E);
    step();
    alarmFlag = 1; #1;
    check("R6 visible at once", 7'h77);
    for (int n = 1; n <= 9; n++) begin
      step();
      check("R6 cadence", ((n / HALF) % 2 == 0) ? 7'h77 : 7'h00);
    end
    // n = 9: blank is next at n=10 not; currently floor(9/3)=3 -> blank
    check("R7 blank before reset", 7'h00);

    // R7: reset during blank with alarm held
    rst = 1; step();
    check("R7 alarm during reset", 7'h77);
    rst = 0;
    for (int n = 1; n <= 4; n++) begin
      step();
      check("R7 cadence after reset", ((n / HALF) % 2 == 0) ? 7'h77 : 7'h00);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule